// File: doc/BRIEF.md
# Prescaled 8/16-bit Timer Counter

This block is a timer/counter that a CPU reaches through four byte-wide registers. It counts one of two tick sources. The first is an instruction-rate enable pulse from the core. The second is an external input, brought through a synchronizer with a chosen edge polarity. Ahead of the counter sits an optional prescaler that divides ticks by a power of two from 2 to 256. Software cannot see the prescaler. Its ratio and whether it is used come only from control bits. The counter is either 8 or 16 bits wide. When it wraps, a sticky flag is set, and that flag, gated by an enable bit, drives the interrupt request.

A 16-bit value moves as one piece through a holding byte. In 16-bit mode, reading the low byte captures the live high byte into the holding byte, and the high-byte address always returns the holding byte. Writing the low byte loads the live high byte from the holding byte in the same cycle. Any write to the low byte also clears the prescaler's internal count. The ratio and the assignment stay as they were.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control register reads 8'hA7. In that value bit7 is run (1), bit6 is wide (0 means 8-bit), bit5 is external source (1), bit4 is falling edge (0 means rising), bit3 is prescaler bypass (0 means the prescaler is used) and bits2:0 are the ratio select (7). After reset the count reads 0, the flag/enable register reads 0 and irq is 0.
- R2: With bypass set (bit3=1) and the internal source selected (bit5=0), every cycle in which cyc_en is high adds one to the count.
- R3: With bypass clear, the count advances once every 2^(sel+1) ticks, where sel is control bits2:0.
- R4: A write to the low count byte (address 1) clears the prescaler's internal count, and the control register keeps its value.
- R5: In 8-bit mode the low byte wraps from 8'hFF to 8'h00 and the live high byte does not change. The wrap sets the flag, which is bit0 of the flag/enable register at address 3.
- R6: In 16-bit mode the count wraps from 16'hFFFF to 16'h0000, and that wrap sets the flag.
- R7: In 16-bit mode a read of address 1 copies the live high byte into the holding byte. Address 2 reads the holding byte, and a write to address 2 changes only the holding byte. A write to address 1 loads the live high byte from the holding byte.
- R8: The flag stays set until software writes 0 to bit0 of address 3. The irq output is the flag ANDed with the enable bit, which is bit1 of address 3.
- R9: With the external source selected, a transition on ext_in reaches the count no earlier than the third clock edge after it. Only the transition selected by bit4 is counted: a rising one when bit4 is 0, a falling one when bit4 is 1.
- R10: While run (bit7) is 0, ticks do not change the count or the prescaler, and register writes still take effect.
- R11: Read data appears on rdata one clock after the cycle in which rd_en is high. Address 0 is control, 1 is the low count byte, 2 is the holding byte, and 3 is {6'b0, enable, flag}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Instruction-rate tick for the internal source |
| ext_in | input | 1 | Asynchronous external count input |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Masked overflow interrupt request |

## Verification
The bench uses the defaults: two synchronizer stages, an 8-bit prescaler and 8-bit bytes. With two stages, the zero read taken two edges after an ext_in change shows the synchronizer delay, and a later read shows the counted edge. With the 8-bit prescaler, ratios of 1:2 and 1:8 can be checked in a few dozen ticks. The clear done by a count write is checked by stopping three ticks short of a prescaler period. Wraps in both widths are reached by preloading the count one or two ticks below the top.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int CTRL_W = 8;

  typedef struct packed {
    logic       run;
    logic       wide;
    logic       ext_src;
    logic       fall_edge;
    logic       ps_bypass;
    logic [2:0] ps_sel;
  } tmr_ctrl_t;

  localparam tmr_ctrl_t CTRL_RESET = '{run: 1'b1, wide: 1'b0, ext_src: 1'b1,
                                       fall_edge: 1'b0, ps_bypass: 1'b0,
                                       ps_sel: 3'd7};

  typedef enum logic [1:0] {
    A_CTRL   = 2'd0,
    A_CNT_LO = 2'd1,
    A_CNT_HI = 2'd2,
    A_IRQ    = 2'd3
  } reg_addr_t;
endpackage

// File: rtl/tick_src.sv
module tick_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cyc_en,
  input  logic ext_in,
  input  logic ext_src,
  input  logic fall_edge,
  output logic tick
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   synced;
  logic                   ext_tick;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_in};
      last_q <= synced;
    end
  end

  always_comb begin
    ext_tick = fall_edge ? (last_q & ~synced) : (synced & ~last_q);
    tick     = ext_src ? ext_tick : cyc_en;
  end

  // R9: a rising-edge tick leaves the edge detector holding a high level
  assert_rise_edge_R9: assert property (@(posedge clk) disable iff (rst)
    (ext_src && !fall_edge && tick) |=> last_q);
  // R9: a falling-edge tick leaves the edge detector holding a low level
  assert_fall_edge_R9: assert property (@(posedge clk) disable iff (rst)
    (ext_src && fall_edge && tick) |=> !last_q);
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int PS_BITS = 8,
  localparam int SEL_W = $clog2(PS_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             bypass,
  input  logic [SEL_W-1:0] sel,
  input  logic             clr,
  output logic             inc
);
  logic [PS_BITS-1:0] pcount_q;
  logic [PS_BITS-1:0] mask;
  logic               hit;

  always_comb begin
    for (int i = 0; i < PS_BITS; i++) mask[i] = (i <= int'(sel));
    hit = ((pcount_q & mask) == mask);
    inc = run & tick & (bypass | hit);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) pcount_q <= '0;
    else if (run && tick && !bypass) pcount_q <= pcount_q + 1'b1;
  end

  // R4: a count write leaves the prescaler at zero
  assert_ps_clear_R4: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pcount_q == '0));
  // R10: stopped timer holds the prescaler
  assert_ps_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(pcount_q));
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int BYTE_W = 8,
  localparam int CW = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic              wide,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              rd_lo,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] hold_hi,
  output logic              ovf
);
  logic [BYTE_W-1:0] lo_q, hi_q, hold_q;
  logic [CW-1:0]     full_next;

  always_comb begin
    full_next = {hi_q, lo_q} + {{(CW-1){1'b0}}, 1'b1};
    ovf       = inc & ~wr_lo & (wide ? (&{hi_q, lo_q}) : (&lo_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q   <= '0;
      hi_q   <= '0;
      hold_q <= '0;
    end else begin
      if (wr_lo) begin
        lo_q <= wdata;
        if (wide) hi_q <= hold_q;
      end else if (inc) begin
        if (wide) {hi_q, lo_q} <= full_next;
        else      lo_q <= lo_q + 1'b1;
      end
      if (wr_hi)              hold_q <= wdata;
      else if (rd_lo && wide) hold_q <= hi_q;
    end
  end

  assign cnt_lo  = lo_q;
  assign hold_hi = hold_q;

  // R10: no increment and no write means the count holds
  assert_cnt_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    (!inc && !wr_lo) |=> ($stable(lo_q) && $stable(hi_q)));
  // R6: an overflow lands on zero
  assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (ovf && wide) |=> (lo_q == '0 && hi_q == '0));
  // R5: in 8-bit mode the live high byte is untouched by counting
  assert_hi_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!wide && !wr_lo) |=> $stable(hi_q));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PS_BITS     = 8,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_en,
  input  logic              ext_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              irq
);
  tmr_ctrl_t         ctrl_q;
  logic              flag_q, ie_q;
  logic [BYTE_W-1:0] rdata_q;
  logic              tick, inc, ovf;
  logic              wr_ctrl, wr_lo, wr_hi, wr_irq, rd_lo;
  logic [BYTE_W-1:0] cnt_lo, hold_hi;

  always_comb begin
    wr_ctrl = wr_en && (addr == A_CTRL);
    wr_lo   = wr_en && (addr == A_CNT_LO);
    wr_hi   = wr_en && (addr == A_CNT_HI);
    wr_irq  = wr_en && (addr == A_IRQ);
    rd_lo   = rd_en && (addr == A_CNT_LO);
  end

  tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .ext_in(ext_in),
    .ext_src(ctrl_q.ext_src), .fall_edge(ctrl_q.fall_edge), .tick(tick)
  );

  tick_prescaler #(.PS_BITS(PS_BITS)) u_ps (
    .clk(clk), .rst(rst), .tick(tick), .run(ctrl_q.run),
    .bypass(ctrl_q.ps_bypass), .sel(ctrl_q.ps_sel), .clr(wr_lo), .inc(inc)
  );

  tick_counter #(.BYTE_W(BYTE_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(inc), .wide(ctrl_q.wide), .wr_lo(wr_lo),
    .wr_hi(wr_hi), .rd_lo(rd_lo), .wdata(wdata), .cnt_lo(cnt_lo),
    .hold_hi(hold_hi), .ovf(ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= CTRL_RESET;
      flag_q  <= 1'b0;
      ie_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= tmr_ctrl_t'(wdata[CTRL_W-1:0]);
      if (ovf)         flag_q <= 1'b1;
      else if (wr_irq) flag_q <= wdata[0];
      if (wr_irq) ie_q <= wdata[1];
      if (rd_en) begin
        case (addr)
          A_CTRL:   rdata_q <= BYTE_W'(ctrl_q);
          A_CNT_LO: rdata_q <= cnt_lo;
          A_CNT_HI: rdata_q <= hold_hi;
          default:  rdata_q <= {{(BYTE_W-2){1'b0}}, ie_q, flag_q};
        endcase
      end
    end
  end

  assign rdata = rdata_q;
  assign irq   = flag_q & ie_q;

  // R8: the flag persists unless software clears it
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(wr_irq && !wdata[0])) |=> flag_q);
  // R5: an overflow from the counter always raises the flag
  assert_flag_set_R5: assert property (@(posedge clk) disable iff (rst)
    ovf |=> flag_q);
  // R10: a stopped timer produces no increments
  assert_no_inc_stopped_R10: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q.run |-> !inc);
endmodule

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_en = 1'b0, ext_in = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_pend = 1'b0;

  tick_timer u_tick_timer (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .ext_in(ext_in),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  always @(posedge clk) rd_pend <= rd_en;

  always @(negedge clk) begin
    if (rd_pend) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s: rdata actual %02h expected %02h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cyc_en = 1'b1;
      @(negedge clk); cyc_en = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: irq actual %0b expected %0b", t, irq, e);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(2'd0, 8'hA7, "R1 ctrl");
    rd(2'd1, 8'h00, "R1 count");
    rd(2'd3, 8'h00, "R1 flag");
    chk_irq(1'b0, "R1 irq");
    // R2 internal source, bypass
    wr(2'd0, 8'h88);
    pulses(5);
    rd(2'd1, 8'h05, "R2 direct ticks");
    // R3 ratios 1:2 and 1:8
    wr(2'd0, 8'h80); wr(2'd1, 8'h00);
    pulses(10);
    rd(2'd1, 8'h05, "R3 ratio 1:2");
    wr(2'd0, 8'h82); wr(2'd1, 8'h00);
    pulses(16);
    rd(2'd1, 8'h02, "R3 ratio 1:8");
    // R4 count write clears the prescaler
    wr(2'd1, 8'h00); pulses(5);
    wr(2'd1, 8'h00); pulses(3);
    rd(2'd1, 8'h00, "R4 prescaler cleared");
    pulses(5);
    rd(2'd1, 8'h01, "R4 full period after clear");
    rd(2'd0, 8'h82, "R4 settings kept");
    // R5 8-bit wrap and flag
    wr(2'd0, 8'h88); wr(2'd1, 8'hFE); wr(2'd3, 8'h02);
    pulses(1);
    rd(2'd1, 8'hFF, "R5 before wrap");
    chk_irq(1'b0, "R8 no flag yet");
    pulses(1);
    rd(2'd1, 8'h00, "R5 wrapped");
    rd(2'd3, 8'h03, "R5 flag set");
    chk_irq(1'b1, "R8 irq raised");
    // R8 sticky, clear, mask
    pulses(1);
    chk_irq(1'b1, "R8 sticky");
    wr(2'd3, 8'h02);
    chk_irq(1'b0, "R8 cleared");
    wr(2'd3, 8'h00); wr(2'd1, 8'hFF); pulses(1);
    rd(2'd3, 8'h01, "R8 flag while masked");
    chk_irq(1'b0, "R8 masked");
    wr(2'd3, 8'h00);
    // R5 live high byte untouched in 8-bit mode (seen once widened)
    wr(2'd0, 8'hC8);
    rd(2'd1, 8'h00, "R5 low after widen");
    rd(2'd2, 8'h00, "R5 high byte stayed zero");
    // R6 16-bit wrap
    wr(2'd2, 8'hFF); wr(2'd1, 8'hFF);
    pulses(1);
    rd(2'd1, 8'h00, "R6 low wrapped");
    rd(2'd2, 8'h00, "R6 high wrapped");
    rd(2'd3, 8'h01, "R6 flag set");
    wr(2'd3, 8'h00);
    // R7 buffered access
    wr(2'd2, 8'h12); wr(2'd1, 8'hFF);
    rd(2'd1, 8'hFF, "R7 low read");
    pulses(1);
    rd(2'd2, 8'h12, "R7 held high from earlier read");
    rd(2'd1, 8'h00, "R7 low after carry");
    rd(2'd2, 8'h13, "R7 new high captured");
    wr(2'd2, 8'hAB); wr(2'd1, 8'h01);
    rd(2'd1, 8'h01, "R7 low written");
    rd(2'd2, 8'hAB, "R7 high loaded from holding byte");
    // R10 stopped
    wr(2'd0, 8'h48);
    pulses(4);
    rd(2'd1, 8'h01, "R10 frozen");
    wr(2'd1, 8'h20);
    rd(2'd1, 8'h20, "R10 write while stopped");
    // R9 external rising edges with synchronizer delay
    wr(2'd0, 8'hA8); wr(2'd1, 8'h00);
    @(negedge clk); ext_in = 1'b1;
    rd(2'd1, 8'h00, "R9 not yet through synchronizer");
    rd(2'd1, 8'h01, "R9 rising edge counted");
    @(negedge clk); ext_in = 1'b0;
    idle(5);
    rd(2'd1, 8'h01, "R9 falling edge ignored");
    wr(2'd0, 8'hB8);
    @(negedge clk); ext_in = 1'b1;
    idle(5);
    rd(2'd1, 8'h01, "R9 rising edge ignored in falling mode");
    @(negedge clk); ext_in = 1'b0;
    idle(5);
    rd(2'd1, 8'h02, "R9 falling edge counted");
    // R11 read latency is covered by every read above
    idle(3);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule